// File: doc/BRIEF.md
# Comparator Event Interrupt Logic

This block is the digital back end of an analog comparator inside a small microcontroller. It receives the comparator's raw one-bit decision, synchronises it into the core clock domain, and shows the synchronised level as a read-only status bit. It watches that level for the event chosen by software: a rising edge, a falling edge or any change. When the event occurs it latches an interrupt flag. An interrupt request goes out when the flag, the local enable and the global interrupt enable are all set.

Software reaches the block through one byte-wide control/status register with a plain write strobe and a continuously driven read value. The flag clears in two ways. The interrupt controller can pulse an acknowledge when it takes the vector. Software can also write a one to the flag bit. A disable bit turns the comparator off and forces the status level low. The falling edge this can cause is passed through as a real event and is not filtered out.

Top module: `cmp_evt_irq`

## Requirements
- R1: After reset every register bit reads 0 and the interrupt request is 0.
- R2: The output status bit (bit 5) follows the raw comparator input through a two-stage synchroniser. A change at the input appears on the bit after the second rising clock edge. While the disable bit is 1, the output status bit reads 0.
- R3: The mode field (bits 1:0) selects which change of the output status bit sets the flag (bit 4). The encoding is 00 for any change, 10 for a falling edge and 11 for a rising edge. The flag is set on the clock edge after the change becomes visible.
- R4: Mode 01 is reserved, and in that mode no change of the comparator sets the flag.
- R5: A register write with bit 4 = 1 clears the flag. A write with bit 4 = 0 leaves it as it was, so reading the register and writing the same value back clears a flag that was set.
- R6: A one-cycle pulse on the acknowledge input clears the flag.
- R7: If a selected event happens in the same cycle as a clear by acknowledge or by write, the flag ends up set.
- R8: The interrupt request is 1 exactly when the flag, the enable bit (bit 3) and the global interrupt enable input are all 1.
- R9: Setting the disable bit while the output status bit is 1 counts as a falling edge. In mode 00 or 10 this sets the flag.
- R10: Register layout: bit 7 is disable, bit 5 is output (read-only), bit 4 is the flag, bit 3 is enable, and bits 1:0 are the mode. Bits 6 and 2 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| cmp_raw_i | input | 1 | Raw comparator decision, asynchronous |
| reg_wr_i | input | 1 | Write strobe for the control/status register |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Current register value |
| irq_ack_i | input | 1 | Vector acknowledge from the interrupt controller, clears the flag |
| gie_i | input | 1 | Global interrupt enable |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest cases to reach are those where a selected edge and a flag clear land in the same cycle. The edge only becomes visible two clock edges after the raw input moves, so the bench has to time the raw change against the acknowledge or the write. A second hard case is the spurious falling edge caused by the disable write, which needs a high comparator level, an enabled mode and a cleared flag all at once. Directed sequences set up each of these situations. Long random runs with a cycle-accurate bench model then mix writes, acknowledges and input changes in every relative phase.

// File: rtl/cmp_evt_pkg.sv
package cmp_evt_pkg;
   localparam int REG_W   = 8;
   localparam int B_DIS   = 7;
   localparam int B_OUT   = 5;
   localparam int B_FLAG  = 4;
   localparam int B_EN    = 3;
   localparam int B_MODE0 = 0;
   localparam int MODE_W  = 2;

   typedef enum logic [MODE_W-1:0] {
      EV_ANY  = 2'b00,
      EV_NONE = 2'b01,
      EV_FALL = 2'b10,
      EV_RISE = 2'b11
   } ev_mode_e;
endpackage

// File: rtl/cmp_sync.sv
module cmp_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_i,
   input  logic dis_i,
   output logic lvl_o
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("cmp_sync: STAGES must be at least 2");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (!rst_n) chain[0] <= 1'b0;
               else        chain[0] <= raw_i;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (!rst_n) chain[i] <= 1'b0;
               else        chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   assign lvl_o = dis_i ? 1'b0 : chain[STAGES-1];

   p_dis_forces_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
      dis_i |-> !lvl_o);
endmodule

// File: rtl/cmp_edge_sel.sv
module cmp_edge_sel
   import cmp_evt_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     lvl_i,
   input  ev_mode_e mode_i,
   output logic     evt_o
);
   logic prev;
   logic rise, fall;

   always_ff @(posedge clk) begin
      if (!rst_n) prev <= 1'b0;
      else        prev <= lvl_i;
   end

   assign rise = lvl_i & ~prev;
   assign fall = ~lvl_i & prev;

   always_comb begin
      unique case (mode_i)
         EV_ANY:  evt_o = rise | fall;
         EV_FALL: evt_o = fall;
         EV_RISE: evt_o = rise;
         default: evt_o = 1'b0;
      endcase
   end

   p_reserved_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == EV_NONE) |-> !evt_o);
   p_evt_needs_change_r3: assert property (@(posedge clk) disable iff (!rst_n)
      evt_o |=> ($past(lvl_i) != $past(prev)));
endmodule

// File: rtl/cmp_ctrl_reg.sv
module cmp_ctrl_reg
   import cmp_evt_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_i,
   input  logic [REG_W-1:0] wdata_i,
   input  logic             ack_i,
   input  logic             evt_i,
   output logic             dis_o,
   output logic             en_o,
   output ev_mode_e         mode_o,
   output logic             flag_o
);
   logic clr;

   assign clr = ack_i | (wr_i & wdata_i[B_FLAG]);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dis_o  <= 1'b0;
         en_o   <= 1'b0;
         mode_o <= EV_ANY;
      end else if (wr_i) begin
         dis_o  <= wdata_i[B_DIS];
         en_o   <= wdata_i[B_EN];
         mode_o <= ev_mode_e'(wdata_i[B_MODE0 +: MODE_W]);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     flag_o <= 1'b0;
      else if (evt_i) flag_o <= 1'b1;
      else if (clr)   flag_o <= 1'b0;
   end

   p_evt_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
      evt_i |=> flag_o);
   p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && !evt_i) |=> !flag_o);
   p_w1c_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && wdata_i[B_FLAG] && !evt_i) |=> !flag_o);
   p_w0_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_o && !ack_i && !(wr_i && wdata_i[B_FLAG])) |=> flag_o);
endmodule

// File: rtl/cmp_evt_irq.sv
module cmp_evt_irq
   import cmp_evt_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmp_raw_i,
   input  logic             reg_wr_i,
   input  logic [REG_W-1:0] reg_wdata_i,
   output logic [REG_W-1:0] reg_rdata_o,
   input  logic             irq_ack_i,
   input  logic             gie_i,
   output logic             irq_o
);
   logic     dis, en, flag, lvl, evt;
   ev_mode_e mode;

   cmp_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk(clk), .rst_n(rst_n), .raw_i(cmp_raw_i), .dis_i(dis), .lvl_o(lvl)
   );

   cmp_edge_sel edge_i (
      .clk(clk), .rst_n(rst_n), .lvl_i(lvl), .mode_i(mode), .evt_o(evt)
   );

   cmp_ctrl_reg ctrl_i (
      .clk(clk), .rst_n(rst_n), .wr_i(reg_wr_i), .wdata_i(reg_wdata_i),
      .ack_i(irq_ack_i), .evt_i(evt), .dis_o(dis), .en_o(en),
      .mode_o(mode), .flag_o(flag)
   );

   always_comb begin
      reg_rdata_o = '0;
      reg_rdata_o[B_DIS]  = dis;
      reg_rdata_o[B_OUT]  = lvl;
      reg_rdata_o[B_FLAG] = flag;
      reg_rdata_o[B_EN]   = en;
      reg_rdata_o[B_MODE0 +: MODE_W] = mode;
   end

   assign irq_o = flag & en & gie_i;

   p_irq_needs_gie_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (gie_i && reg_rdata_o[B_EN]));
   p_dis_out_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata_o[B_DIS] |-> !reg_rdata_o[B_OUT]);
   p_spare_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rdata_o[6] && !reg_rdata_o[2]);
endmodule

// File: tb/cmp_evt_irq_tb_top.sv
module cmp_evt_irq_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       raw = 1'b0, wr = 1'b0, ack = 1'b0, gie = 1'b0;
   logic [7:0] wd = '0;
   logic [7:0] rd;
   logic       irq;
   int         checks = 0, errors = 0;

   // bench model
   logic       m_s0 = 0, m_s1 = 0, m_prev = 0, m_flag = 0, m_dis = 0, m_en = 0;
   logic [1:0] m_mode = 2'b00;

   always #2 clk = ~clk;

   cmp_evt_irq dut_i (
      .clk(clk), .rst_n(rst_n), .cmp_raw_i(raw), .reg_wr_i(wr),
      .reg_wdata_i(wd), .reg_rdata_o(rd), .irq_ack_i(ack), .gie_i(gie),
      .irq_o(irq)
   );

   function automatic logic ev_of(input logic [1:0] mode, input logic p, input logic c);
      case (mode)
         2'b00:   return p != c;
         2'b10:   return p & ~c;
         2'b11:   return ~p & c;
         default: return 1'b0;
      endcase
   endfunction

   function automatic logic [7:0] exp_reg();
      logic lvl = m_dis ? 1'b0 : m_s1;
      return {m_dis, 1'b0, lvl, m_flag, m_en, 1'b0, m_mode};
   endfunction

   task automatic check(input logic ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
      end
   endtask

   task automatic model_edge();
      logic cur = m_dis ? 1'b0 : m_s1;
      logic ev  = ev_of(m_mode, m_prev, cur);
      if (ev) m_flag = 1'b1;
      else if (ack || (wr && wd[4])) m_flag = 1'b0;
      m_prev = cur;
      m_s1 = m_s0;
      m_s0 = raw;
      if (wr) begin
         m_dis = wd[7]; m_en = wd[3]; m_mode = wd[1:0];
      end
   endtask

   task automatic compare_all();
      logic [7:0] e = exp_reg();
      logic ei = m_flag & m_en & gie;
      check(rd[5] == e[5], "R2 output bit", {7'b0, rd[5]}, {7'b0, e[5]});
      check(rd[4] == e[4], "R3 flag", {7'b0, rd[4]}, {7'b0, e[4]});
      check(rd == e, "R10 register", rd, e);
      check(irq == ei, "R8 irq", {7'b0, irq}, {7'b0, ei});
   endtask

   task automatic step(input logic r, input logic w, input logic [7:0] d,
                       input logic a, input logic g);
      @(negedge clk);
      raw = r; wr = w; wd = d; ack = a; gie = g;
      @(posedge clk);
      model_edge();
      #1;
      compare_all();
   endtask

   initial begin
      #(4 * 150000);
      errors++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int unsigned seed = 32'd12345;
      void'($urandom(seed));
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(rd == 8'h00, "R1 reset reg", rd, 8'h00);
      check(irq == 1'b0, "R1 reset irq", {7'b0, irq}, 8'h00);
      rst_n = 1'b1;

      // R9: disable while output high gives falling event in mode 00
      step(1, 1, 8'h18, 0, 1);             // enable, mode any, clear flag
      repeat (4) step(1, 0, 8'h00, 0, 1);
      step(1, 1, 8'h18, 0, 1);             // clear flag raised by rise
      step(1, 1, 8'h88, 0, 1);             // set disable
      step(1, 0, 8'h00, 0, 1);             // level forced low -> event
      step(1, 0, 8'h00, 0, 1);
      check(rd[4] == 1'b1, "R9 spurious flag", rd, 8'h10);

      // R5: read-modify-write of enable keeps flag=1 and clears it
      step(1, 1, rd & 8'hf7 | 8'h00, 0, 1);
      check(rd[4] == 1'b0, "R5 rmw clears flag", rd, 8'h00);

      // R4: reserved mode, toggle raw, flag must stay clear
      step(0, 1, 8'h09, 0, 1);
      for (int i = 0; i < 10; i++) step(i[0], 0, 8'h00, 0, 1);
      check(rd[4] == 1'b0, "R4 reserved mode", rd, 8'h00);

      // R7: rise event visible in the same cycle as ack
      step(0, 1, 8'h0b, 0, 1);
      repeat (3) step(0, 0, 8'h00, 0, 1);
      step(1, 0, 8'h00, 0, 1);
      step(1, 0, 8'h00, 0, 1);             // level now high, event pending
      step(1, 0, 8'h00, 1, 1);             // ack in event cycle
      check(rd[4] == 1'b1, "R7 set beats clear", rd, 8'h10);

      // R6: plain ack clears
      step(1, 0, 8'h00, 1, 1);
      check(rd[4] == 1'b0, "R6 ack clears", rd, 8'h00);

      // random phase
      for (int i = 0; i < 4000; i++) begin
         logic w = ($urandom % 8) == 0;
         logic a = ($urandom % 16) == 0;
         step(logic'($urandom % 2), w, 8'($urandom), a, logic'($urandom % 2));
      end

      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule